// File: doc/BRIEF.md
# Sixteen-bit match/capture counter-timer with PWM

This block is a general-purpose counter-timer for a processor subsystem. A 16-bit count register advances either on a prescaled version of the system clock or on synchronized edges of one chosen capture input. Four match registers are compared against the count on every count tick. A match can raise a flag, return the count to zero, halt counting, and change one of two external match outputs. Four capture channels copy the count into their own capture registers on a programmed edge. Two of these channels come from package pins. The other two carry the level and edge outputs of on-chip comparators, which arrive as plain digital signals.

Software reaches the block through a synchronous word port. A write takes effect at the clock edge that samples it. Read data is registered and appears one cycle after the address. All event flags are sticky and combine into one interrupt line. In PWM mode, match channel 3 sets the period and match channels 0 and 1 set the switching points of the two outputs.

Top module: `mct_timer`

## Requirements
- R1: After synchronous reset the count, prescale counter, all flags and both match outputs are zero, `irq` is low and counting is halted.
- R2: In clock mode (MODE[1:0]=0) with CTRL[0]=1, the count advances once every PRESCALE+1 clock cycles. Register addresses are CTRL=0, MODE=1, PRESCALE=2, COUNT=3.
- R3: On a count tick where the count equals match register i (addresses 16+i), match flag i (IRQ register address 9, bit i) is set if MCTL (address 5) bit 3i is set. `irq` is the OR of all flags.
- R4: A match tick whose MCTL bit 3i+1 is set loads zero into the count instead of incrementing it. If MCTL bit 3i+2 is also set, the reset wins and counting continues.
- R5: A match tick whose MCTL bit 3i+2 is set holds the count at the match value and clears CTRL[0].
- R6: On a match of channel j (j=0,1), the match output j takes the action in EXT (address 7) bits [5+2j:4+2j]: 0 none, 1 low, 2 high, 3 toggle. EXT bits [1:0] read and write the output states directly.
- R7: Capture channel c copies the count into capture register c (address 24+c) on a rising edge if CCTL (address 6) bit 3c is set, and on a falling edge if bit 3c+1 is set. Capture flag c (IRQ bit 4+c) is set when bit 3c+2 is set. Inputs pass through two synchronizer flops, so a change driven just after edge k captures the count held after edge k+2. An edge whose enable is clear leaves the capture register unchanged.
- R8: Capture channel 2 samples the comparator level input and channel 3 samples the comparator edge input, with the same rules as R7.
- R9: With MODE[1:0] = 1 (rising), 2 (falling) or 3 (both), the count advances once per synchronized edge of the capture channel selected by MODE[3:2]. The prescaler is bypassed.
- R10: When PWM (address 8) bit j is set, output j goes low when the count reaches match 3 and goes high when the count reaches match j. A match-3 tick also returns the count to zero, so the period is MR3+1 ticks.
- R11: Writing a 1 to an IRQ bit clears that flag. A 0 leaves it unchanged. A flag being set in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, one cycle after address |
| cap_pin | input | 2 | External capture inputs, channels 0 and 1 |
| cmp_level | input | 1 | Comparator level signal, capture channel 2 |
| cmp_edge | input | 1 | Comparator edge signal, capture channel 3 |
| mat_out | output | 2 | External match outputs of channels 0 and 1 |
| irq | output | 1 | OR of all sticky flags |

## Verification
The bench builds the block with its default parameters: a 16-bit count, four match and four capture channels, two outputs, and a two-stage synchronizer. With a prescale of 3 and match values under ten, the stop, reset-on-match, PWM wrap and capture latency all fall within a few dozen cycles, so each can be checked at the exact edge. The four-channel capture set puts both comparator inputs within reach alongside the pins. The selectable count source lets pin pulses replace the clock while a large prescale value shows that the prescaler is bypassed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_CTRL = 5'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 5'd1;
  localparam logic [ADDR_W-1:0] A_PRE  = 5'd2;
  localparam logic [ADDR_W-1:0] A_TC   = 5'd3;
  localparam logic [ADDR_W-1:0] A_PC   = 5'd4;
  localparam logic [ADDR_W-1:0] A_MCTL = 5'd5;
  localparam logic [ADDR_W-1:0] A_CCTL = 5'd6;
  localparam logic [ADDR_W-1:0] A_EXT  = 5'd7;
  localparam logic [ADDR_W-1:0] A_PWM  = 5'd8;
  localparam logic [ADDR_W-1:0] A_IRQ  = 5'd9;
  localparam logic [ADDR_W-1:0] A_MR0  = 5'd16;
  localparam logic [ADDR_W-1:0] A_CR0  = 5'd24;

  localparam int ACT_LSB = 4;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } ext_act_e;

  typedef enum logic [1:0] {
    SRC_CLK  = 2'd0,
    SRC_RISE = 2'd1,
    SRC_FALL = 2'd2,
    SRC_BOTH = 2'd3
  } cnt_src_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         tick,
  output logic [W-1:0] pc
);
  logic wrap;

  assign wrap = (pc >= limit);
  assign tick = en & wrap;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pc <= '0;
    end else if (en) begin
      pc <= wrap ? '0 : pc + W'(1);
    end
  end
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int W = 16,
  parameter int N = 4
) (
  input  logic              tick,
  input  logic [W-1:0]      tc,
  input  logic [N-1:0][W-1:0] mr,
  output logic [N-1:0]      evt
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign evt[i] = tick && (tc == mr[i]);
  end
endmodule

// File: rtl/mct_timer.sv
module mct_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int N_MATCH     = 4,
  parameter int N_CAP       = 4,
  parameter int N_EXT       = 2,
  parameter int PWM_CYC     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [N_CAP-3:0]  cap_pin,
  input  logic              cmp_level,
  input  logic              cmp_edge,
  output logic [N_EXT-1:0]  mat_out,
  output logic              irq
);
  localparam int SEL_W = (N_CAP > 1) ? $clog2(N_CAP) : 1;
  localparam int NF    = N_MATCH + N_CAP;

  // control state
  logic                         run_q, clr_q;
  cnt_src_e                     src_q;
  logic [SEL_W-1:0]             sel_q;
  logic [CNT_W-1:0]             pr_q, tc_q, pc;
  logic [3*N_MATCH-1:0]         mctl_q;
  logic [3*N_CAP-1:0]           cctl_q;
  logic [N_EXT-1:0]             ext_q, pwm_q, ext_nxt;
  logic [N_EXT-1:0][1:0]        act_q;
  logic [NF-1:0]                flags_q, flag_set, flag_clr;
  logic [N_MATCH-1:0][CNT_W-1:0] mr_q;
  logic [N_CAP-1:0][CNT_W-1:0]  cr_q;
  logic [CNT_W-1:0]             rd_nxt;

  // decoded fields and events
  logic [N_MATCH-1:0] m_int, m_rst, m_stp, m_evt;
  logic [N_CAP-1:0]   c_rise_en, c_fall_en, c_int, cap_hit;
  logic [N_CAP-1:0]   cap_raw, cap_rise, cap_fall;
  logic               clk_mode, pre_tick, edge_tick, tick;
  logic               rst_hit, stop_hit, cyc_evt, pwm_any;
  logic               wr_ctrl, wr_tc;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_tc   = bus_wr && (bus_addr == A_TC);

  always_comb begin
    for (int i = 0; i < N_MATCH; i++) begin
      m_int[i] = mctl_q[3*i];
      m_rst[i] = mctl_q[3*i+1];
      m_stp[i] = mctl_q[3*i+2];
    end
    for (int c = 0; c < N_CAP; c++) begin
      c_rise_en[c] = cctl_q[3*c];
      c_fall_en[c] = cctl_q[3*c+1];
      c_int[c]     = cctl_q[3*c+2];
    end
  end

  // capture inputs: pins first, then comparator level and edge
  assign cap_raw = {cmp_edge, cmp_level, cap_pin};

  for (genvar c = 0; c < N_CAP; c++) begin : g_sync
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (cap_raw[c]),
      .rise (cap_rise[c]),
      .fall (cap_fall[c])
    );
  end

  // count source
  assign clk_mode = (src_q == SRC_CLK);

  tmr_prescale #(.W(CNT_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .en    (run_q && clk_mode),
    .clr   (clr_q || wr_tc),
    .limit (pr_q),
    .tick  (pre_tick),
    .pc    (pc)
  );

  assign edge_tick = run_q && !clk_mode &&
                     ((((src_q == SRC_RISE) || (src_q == SRC_BOTH)) && cap_rise[sel_q]) ||
                      (((src_q == SRC_FALL) || (src_q == SRC_BOTH)) && cap_fall[sel_q]));
  assign tick = pre_tick | edge_tick;

  tmr_match #(.W(CNT_W), .N(N_MATCH)) u_match (
    .tick (tick),
    .tc   (tc_q),
    .mr   (mr_q),
    .evt  (m_evt)
  );

  assign pwm_any  = |pwm_q;
  assign cyc_evt  = m_evt[PWM_CYC];
  assign rst_hit  = |(m_evt & m_rst) || (pwm_any && cyc_evt);
  assign stop_hit = |(m_evt & m_stp);

  // counter and control
  always_ff @(posedge clk) begin
    if (rst) begin
      tc_q <= '0;
    end else if (clr_q) begin
      tc_q <= '0;
    end else if (wr_tc) begin
      tc_q <= bus_wdata;
    end else if (tick) begin
      if (rst_hit)       tc_q <= '0;
      else if (!stop_hit) tc_q <= tc_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      clr_q <= 1'b0;
    end else if (wr_ctrl) begin
      run_q <= bus_wdata[0];
      clr_q <= bus_wdata[1];
    end else if (tick && stop_hit && !rst_hit) begin
      run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= SRC_CLK;
      sel_q  <= '0;
      pr_q   <= '0;
      mctl_q <= '0;
      cctl_q <= '0;
      pwm_q  <= '0;
      act_q  <= '0;
      mr_q   <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_MODE) begin
        src_q <= cnt_src_e'(bus_wdata[1:0]);
        sel_q <= bus_wdata[2 +: SEL_W];
      end
      if (bus_addr == A_PRE)  pr_q   <= bus_wdata;
      if (bus_addr == A_MCTL) mctl_q <= bus_wdata[3*N_MATCH-1:0];
      if (bus_addr == A_CCTL) cctl_q <= bus_wdata[3*N_CAP-1:0];
      if (bus_addr == A_PWM)  pwm_q  <= bus_wdata[N_EXT-1:0];
      if (bus_addr == A_EXT) begin
        for (int j = 0; j < N_EXT; j++) act_q[j] <= bus_wdata[ACT_LSB+2*j +: 2];
      end
      for (int i = 0; i < N_MATCH; i++) begin
        if (bus_addr == A_MR0 + ADDR_W'(i)) mr_q[i] <= bus_wdata;
      end
    end
  end

  // external match outputs
  always_comb begin
    for (int j = 0; j < N_EXT; j++) begin
      ext_nxt[j] = ext_q[j];
      if (pwm_q[j]) begin
        if (cyc_evt)       ext_nxt[j] = 1'b0;
        else if (m_evt[j]) ext_nxt[j] = 1'b1;
      end else if (m_evt[j]) begin
        case (ext_act_e'(act_q[j]))
          ACT_LOW:    ext_nxt[j] = 1'b0;
          ACT_HIGH:   ext_nxt[j] = 1'b1;
          ACT_TOGGLE: ext_nxt[j] = ~ext_q[j];
          default:    ext_nxt[j] = ext_q[j];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                              ext_q <= '0;
    else if (bus_wr && bus_addr == A_EXT) ext_q <= bus_wdata[N_EXT-1:0];
    else                                  ext_q <= ext_nxt;
  end

  assign mat_out = ext_q;

  // capture registers
  assign cap_hit = (c_rise_en & cap_rise) | (c_fall_en & cap_fall);

  always_ff @(posedge clk) begin
    if (rst) begin
      cr_q <= '0;
    end else begin
      for (int c = 0; c < N_CAP; c++) begin
        if (cap_hit[c]) cr_q[c] <= tc_q;
      end
    end
  end

  // sticky flags
  assign flag_set = {cap_hit & c_int, m_evt & m_int};
  assign flag_clr = (bus_wr && bus_addr == A_IRQ) ? bus_wdata[NF-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~flag_clr) | flag_set;
  end

  assign irq = |flags_q;

  // read port
  always_comb begin
    rd_nxt = '0;
    case (bus_addr)
      A_CTRL: rd_nxt = CNT_W'({clr_q, run_q});
      A_MODE: rd_nxt = CNT_W'({sel_q, src_q});
      A_PRE:  rd_nxt = pr_q;
      A_TC:   rd_nxt = tc_q;
      A_PC:   rd_nxt = pc;
      A_MCTL: rd_nxt = CNT_W'(mctl_q);
      A_CCTL: rd_nxt = CNT_W'(cctl_q);
      A_PWM:  rd_nxt = CNT_W'(pwm_q);
      A_IRQ:  rd_nxt = CNT_W'(flags_q);
      A_EXT: begin
        rd_nxt[N_EXT-1:0] = ext_q;
        for (int j = 0; j < N_EXT; j++) rd_nxt[ACT_LSB+2*j +: 2] = act_q[j];
      end
      default: rd_nxt = '0;
    endcase
    for (int i = 0; i < N_MATCH; i++) begin
      if (bus_addr == A_MR0 + ADDR_W'(i)) rd_nxt = mr_q[i];
    end
    for (int c = 0; c < N_CAP; c++) begin
      if (bus_addr == A_CR0 + ADDR_W'(c)) rd_nxt = cr_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_nxt;
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int N_MATCH = 4,
  parameter int N_CAP   = 4,
  parameter int N_EXT   = 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_wr,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [CNT_W-1:0]           tc,
  input logic                       run,
  input logic                       clr,
  input logic [N_MATCH+N_CAP-1:0]   flags,
  input logic [N_MATCH-1:0]         m_evt,
  input logic [N_MATCH-1:0]         m_int,
  input logic [N_MATCH-1:0]         m_rst,
  input logic                       cyc_evt,
  input logic [N_EXT-1:0]           pwm,
  input logic [N_EXT-1:0]           mat_out,
  input logic                       irq
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (tc == '0 && flags == '0 && mat_out == '0 && !irq && !run));

  assert_match_flag_R3: assert property (@(posedge clk) disable iff (rst)
    ((m_evt & m_int) != '0) |=>
      ((flags[N_MATCH-1:0] & $past(m_evt & m_int)) == $past(m_evt & m_int)));

  assert_reset_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (((m_evt & m_rst) != '0) && !bus_wr && !clr) |=> (tc == '0));

  assert_stop_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr && !bus_wr) |=> $stable(tc));

  assert_pwm_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (cyc_evt && (pwm != '0) && !bus_wr) |=> ((mat_out & $past(pwm)) == '0));

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == A_IRQ) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

bind mct_timer tmr_checker #(
  .CNT_W   (CNT_W),
  .N_MATCH (N_MATCH),
  .N_CAP   (N_CAP),
  .N_EXT   (N_EXT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .tc       (tc_q),
  .run      (run_q),
  .clr      (clr_q),
  .flags    (flags_q),
  .m_evt    (m_evt),
  .m_int    (m_int),
  .m_rst    (m_rst),
  .cyc_evt  (cyc_evt),
  .pwm      (pwm_q),
  .mat_out  (mat_out),
  .irq      (irq)
);

// File: tb/test_mct_timer.sv
module test_mct_timer;
  localparam int AW = 5;
  localparam logic [AW-1:0] CTRL = 5'd0, MODE = 5'd1, PRE = 5'd2, TC = 5'd3;
  localparam logic [AW-1:0] MCTL = 5'd5, CCTL = 5'd6, EXT = 5'd7, PWM = 5'd8, IRQR = 5'd9;
  localparam logic [AW-1:0] MR0 = 5'd16, MR1 = 5'd17, MR3 = 5'd19;
  localparam logic [AW-1:0] CR1 = 5'd25, CR2 = 5'd26, CR3 = 5'd27;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic [15:0]   bus_rdata;
  logic [1:0]    cap_pin = '0;
  logic          cmp_level = 1'b0;
  logic          cmp_edge = 1'b0;
  logic [1:0]    mat_out;
  logic          irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mct_timer i_mct_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_pin(cap_pin),
    .cmp_level(cmp_level), .cmp_edge(cmp_edge), .mat_out(mat_out), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1; cap_pin = '0; cmp_level = 1'b0; cmp_edge = 1'b0;
    step(3);
    rst = 1'b0;
  endtask

  task automatic t_reset_r1();
    logic [15:0] v;
    do_reset();
    check("R1 irq", 16'(irq), 16'd0);
    check("R1 mat_out", 16'(mat_out), 16'd0);
    rd(TC, v);   check("R1 count", v, 16'd0);
    rd(IRQR, v); check("R1 flags", v, 16'd0);
    rd(CTRL, v); check("R1 run", v, 16'd0);
  endtask

  task automatic t_prescale_r2();
    logic [15:0] v;
    do_reset();
    wr(PRE, 16'd3);
    wr(MR0, 16'd2);
    wr(MCTL, 16'h5);              // ch0 interrupt + stop
    wr(CTRL, 16'h1);
    step(11); check("R2 R3 no match before 12th edge", 16'(irq), 16'd0);
    step(1);  check("R3 irq on match", 16'(irq), 16'd1);
    rd(TC, v);   check("R5 count held at match", v, 16'd2);
    rd(CTRL, v); check("R5 run cleared", v, 16'd0);
    rd(IRQR, v); check("R3 flag bit0", v, 16'h1);
    wr(IRQR, 16'h2); check("R11 write 0 keeps flag", 16'(irq), 16'd1);
    wr(IRQR, 16'h1); check("R11 write 1 clears flag", 16'(irq), 16'd0);
  endtask

  task automatic t_reset_wins_r4();
    logic [15:0] v;
    do_reset();
    wr(MR0, 16'd3);
    wr(MCTL, 16'h7);              // int + reset + stop
    wr(CTRL, 16'h1);
    step(21);
    rd(TC, v);   check("R4 count wraps modulo 4", v, 16'd1);
    rd(CTRL, v); check("R4 reset beats stop", v, 16'd1);
    check("R4 flag raised", 16'(irq), 16'd1);
  endtask

  task automatic t_ext_r6();
    logic [15:0] v;
    do_reset();
    wr(EXT, 16'h00B0);            // ch0 toggle, ch1 high
    wr(MR0, 16'd4);
    wr(MR1, 16'd6);
    wr(MCTL, 16'h20);             // ch1 stop
    wr(CTRL, 16'h1);
    step(4); check("R6 before match", 16'(mat_out), 16'h0);
    step(1); check("R6 toggle ch0", 16'(mat_out), 16'h1);
    step(2); check("R6 high ch1", 16'(mat_out), 16'h3);
    rd(TC, v); check("R5 held at 6", v, 16'd6);
    do_reset();
    wr(EXT, 16'h0013);            // both high, ch0 low action, ch1 none
    check("R6 direct write", 16'(mat_out), 16'h3);
    wr(MR0, 16'd2);
    wr(MR1, 16'd2);
    wr(MCTL, 16'h20);
    wr(CTRL, 16'h1);
    step(3); check("R6 low action, none keeps ch1", 16'(mat_out), 16'h2);
  endtask

  task automatic t_capture_r7();
    logic [15:0] v;
    do_reset();
    wr(CCTL, 16'h28);             // ch1 rise + int
    wr(CTRL, 16'h1);
    step(4); cap_pin[1] = 1'b1;
    step(10); cap_pin[1] = 1'b0;  // falling edge, not enabled
    step(10);
    wr(CTRL, 16'h0);
    rd(CR1, v);  check("R7 captured count, fall ignored", v, 16'd6);
    rd(IRQR, v); check("R7 capture flag bit5", v, 16'h20);
  endtask

  task automatic t_comparator_r8();
    logic [15:0] v;
    do_reset();
    wr(CCTL, 16'h440);            // ch2 rise, ch3 fall
    wr(CTRL, 16'h1);
    step(2); cmp_level = 1'b1;
    step(3); cmp_edge = 1'b1;
    step(3); cmp_edge = 1'b0;
    step(5);
    wr(CTRL, 16'h0);
    rd(CR2, v); check("R8 level channel", v, 16'd4);
    rd(CR3, v); check("R8 edge channel on fall", v, 16'd10);
    check("R8 no flag without enable", 16'(irq), 16'd0);
  endtask

  task automatic t_counter_r9();
    logic [15:0] v;
    do_reset();
    wr(PRE, 16'd50);
    wr(MODE, 16'h1);              // rising edges of channel 0
    wr(CTRL, 16'h1);
    for (int k = 0; k < 3; k++) begin
      cap_pin[0] = 1'b1; step(3);
      cap_pin[0] = 1'b0; step(3);
    end
    step(4);
    wr(CTRL, 16'h0);
    rd(TC, v); check("R9 counts input edges", v, 16'd3);
  endtask

  task automatic t_pwm_r10();
    do_reset();
    wr(PWM, 16'h1);
    wr(MR0, 16'd3);
    wr(MR3, 16'd8);
    wr(CTRL, 16'h1);
    step(3); check("R10 low at cycle start", 16'(mat_out), 16'h0);
    step(1); check("R10 high at match0", 16'(mat_out), 16'h1);
    step(4); check("R10 still high", 16'(mat_out), 16'h1);
    step(1); check("R10 low at wrap", 16'(mat_out), 16'h0);
    step(4); check("R10 high second period", 16'(mat_out), 16'h1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    step(1);
    t_reset_r1();
    t_prescale_r2();
    t_reset_wins_r4();
    t_ext_r6();
    t_capture_r7();
    t_comparator_r8();
    t_counter_r9();
    t_pwm_r10();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end
endmodule